// File: doc/BRIEF.md
# Lane-Partitioned SIMD Saturating Adder

This block adds or subtracts two 256-bit operand vectors element by element. A lane-size select cuts the vector into 32 bytes, 16 halfwords or 8 words, or into complex pairs. In complex mode each 32-bit slot holds a 16-bit real part in its lower half and a 16-bit imaginary part in its upper half, and the two parts are computed separately. Elements are treated as signed two's-complement values, which covers both plain integers and signed fixed-point fractions. With saturation enabled, a result that leaves the signed range of its element is clamped to the nearest limit, and a flag for that element is set. With saturation disabled, results wrap.

Operands enter through a valid/ready input port. The result leaves one register stage later through a valid/ready output port. A transfer happens on a rising clock edge where valid and ready are both high. Input ready is high whenever the output register is empty or is being drained in the same cycle. A held result stays unchanged until the consumer takes it, so back-pressure passes straight through to the producer.

Top module: `simd_sat_adder`

## Requirements
- R1: With lane select 2'b00, the block computes 32 independent 8-bit results. Element k occupies bits [8k+7:8k].
- R2: With lane select 2'b01, the block computes 16 independent 16-bit results. Element k occupies bits [16k+15:16k].
- R3: With lane select 2'b10, the block computes 8 independent 32-bit results. Element k occupies bits [32k+31:32k].
- R4: With lane select 2'b11 (complex), each 32-bit slot j is split into two parts. The real part sits in bits [32j+15:32j] and is flag element 2j. The imaginary part sits in bits [32j+31:32j+16] and is flag element 2j+1. Each part is added or subtracted on its own.
- R5: Op bit 0 selects a+b. Op bit 1 selects a-b, with both operands read as signed two's complement.
- R6: With saturation enabled, a result above 2^(W-1)-1 becomes that value, and a result below -2^(W-1) becomes that value. W is the element width.
- R7: Flag bit k is 1 exactly when saturation is enabled and element k was clamped. Flag bits at or above the element count are 0, and every flag is 0 when saturation is disabled.
- R8: No carry or borrow passes from one element into the next, in any mode. For example, byte 0xFF + 0x01 gives 0x00 and leaves the neighbouring byte unchanged.
- R9: With saturation disabled, each result equals the exact result modulo 2^W.
- R10: An input accepted on an edge appears with out_valid high right after that edge. Results come out in acceptance order.
- R11: While out_valid is high and out_ready is low, out_data and out_flags hold their values, and in_ready is low.
- R12: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid |
| in_ready | output | 1 | Block can take operands this cycle |
| in_a | input | 256 | First operand vector |
| in_b | input | 256 | Second operand vector |
| in_op | input | 1 | 0 = add, 1 = subtract (a-b) |
| in_mode | input | 2 | Lane select: 00 byte, 01 halfword, 10 word, 11 complex |
| in_sat | input | 1 | 1 = saturate, 0 = wrap |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 256 | Result vector |
| out_flags | output | 32 | Per-element clamp flags |

## Verification
Some properties are checked on every clock cycle:
- the one-cycle acceptance-to-output relation;
- stability of the held result under back-pressure;
- all flags at zero when saturation is off;
- flags confined to the element count;
- the limit value in a clamped byte element.

Other behaviour only the bench's scenarios can show:
- the arithmetic itself in every lane mode;
- isolation at each element boundary;
- the split of the complex halves;
- the correct clamp direction for add and subtract.

The bench compares each result against a reference model written from the requirements, for both directed edge values and random operands, with random output stalls.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;
  typedef enum logic [1:0] {
    LANE_B8  = 2'b00,
    LANE_H16 = 2'b01,
    LANE_W32 = 2'b10,
    LANE_CPX = 2'b11
  } lane_mode_e;

  function automatic int unsigned bytes_per_elem(lane_mode_e m);
    case (m)
      LANE_B8:  return 1;
      LANE_W32: return 4;
      default:  return 2;
    endcase
  endfunction
endpackage

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
  import simd_sat_pkg::*;
#(
  parameter int VEC_W = 256,
  localparam int NB   = VEC_W / 8
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic             sub,
  input  lane_mode_e       mode,
  output logic [VEC_W-1:0] sum,
  output logic [NB-1:0]    ovf,
  output logic [NB-1:0]    neg
);
  logic [NB-1:0] elem_start;
  logic [NB-1:0] cin;
  logic [NB-1:0] cout;

  always_comb begin
    for (int i = 0; i < NB; i++)
      elem_start[i] = ((i % int'(bytes_per_elem(mode))) == 0);
  end

  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [7:0] av;
    logic [7:0] bx;
    logic [8:0] s;
    if (g == 0) begin : g_first
      assign cin[g] = sub;
    end else begin : g_rest
      // chain is cut where a new element begins
      assign cin[g] = elem_start[g] ? sub : cout[g-1];
    end
    assign av       = a[8*g +: 8];
    assign bx       = sub ? ~b[8*g +: 8] : b[8*g +: 8];
    assign s        = {1'b0, av} + {1'b0, bx} + {8'b0, cin[g]};
    assign sum[8*g +: 8] = s[7:0];
    assign cout[g]  = s[8];
    assign ovf[g]   = (av[7] == bx[7]) && (s[7] != av[7]);
    assign neg[g]   = av[7];
  end
endmodule

// File: rtl/simd_sat_clamp.sv
module simd_sat_clamp
  import simd_sat_pkg::*;
#(
  parameter int VEC_W = 256,
  localparam int NB   = VEC_W / 8
) (
  input  logic [VEC_W-1:0] sum,
  input  logic [NB-1:0]    ovf,
  input  logic [NB-1:0]    neg,
  input  lane_mode_e       mode,
  input  logic             sat,
  output logic [VEC_W-1:0] res,
  output logic [NB-1:0]    flags
);
  always_comb begin
    int unsigned e;
    int unsigned top;
    e     = bytes_per_elem(mode);
    flags = '0;
    for (int i = 0; i < NB; i++) begin
      top = int'(i) | (e - 1);
      if (sat && ovf[top]) begin
        if (i == top) res[8*i +: 8] = neg[top] ? 8'h80 : 8'h7F;
        else          res[8*i +: 8] = neg[top] ? 8'h00 : 8'hFF;
      end else begin
        res[8*i +: 8] = sum[8*i +: 8];
      end
    end
    for (int k = 0; k < NB; k++) begin
      if (k < NB / int'(e))
        flags[k] = sat && ovf[k*int'(e) + int'(e) - 1];
    end
  end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
  import simd_sat_pkg::*;
#(
  parameter int VEC_W = 256,
  localparam int NB   = VEC_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] in_a,
  input  logic [VEC_W-1:0] in_b,
  input  logic             in_op,
  input  logic [1:0]       in_mode,
  input  logic             in_sat,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data,
  output logic [NB-1:0]    out_flags
);
  lane_mode_e       mode_in;
  logic [VEC_W-1:0] sum_w;
  logic [VEC_W-1:0] res_w;
  logic [NB-1:0]    ovf_w;
  logic [NB-1:0]    neg_w;
  logic [NB-1:0]    flag_w;
  logic             sat_q;
  lane_mode_e       mode_q;
  logic             take;

  assign mode_in  = lane_mode_e'(in_mode);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  simd_lane_adder #(.VEC_W(VEC_W)) u_add (
    .a(in_a), .b(in_b), .sub(in_op), .mode(mode_in),
    .sum(sum_w), .ovf(ovf_w), .neg(neg_w)
  );

  simd_sat_clamp #(.VEC_W(VEC_W)) u_clamp (
    .sum(sum_w), .ovf(ovf_w), .neg(neg_w), .mode(mode_in), .sat(in_sat),
    .res(res_w), .flags(flag_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_flags <= '0;
      sat_q     <= 1'b0;
      mode_q    <= LANE_B8;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= res_w;
        out_flags <= flag_w;
        sat_q     <= in_sat;
        mode_q    <= mode_in;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assert_accept_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);
  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_flags));
  assert_stall_no_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  assert_flags_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !sat_q |-> out_flags == '0);
  assert_flag_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode_q != LANE_B8 |-> out_flags[NB-1:NB/2] == '0);
  assert_clamp_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode_q == LANE_B8 && out_flags[0] |->
      (out_data[7:0] == 8'h7F || out_data[7:0] == 8'h80));
endmodule

// File: tb/simd_sat_adder_bench.sv
module simd_sat_adder_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] in_a = '0;
  logic [255:0] in_b = '0;
  logic         in_op = 1'b0;
  logic [1:0]   in_mode = 2'b00;
  logic         in_sat = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [255:0] out_data;
  logic [31:0]  out_flags;

  int n_chk = 0;
  int n_bad = 0;
  bit bp_en = 1'b0;
  bit done  = 1'b0;
  logic [255:0] exp_d[$];
  logic [31:0]  exp_f[$];
  string        exp_t[$];

  always #2.5 clk = ~clk;

  simd_sat_adder u_simd_sat_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_op(in_op), .in_mode(in_mode), .in_sat(in_sat),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_flags(out_flags)
  );

  function automatic void ref_model(input logic [255:0] a, input logic [255:0] b,
                                     input logic op, input logic [1:0] mode, input logic sat,
                                     output logic [255:0] d, output logic [31:0] f);
    int w;
    longint mask, x, y, r, hi, lo;
    w    = (mode == 2'b00) ? 8 : (mode == 2'b10) ? 32 : 16;
    mask = (longint'(1) << w) - 1;
    hi   = (longint'(1) << (w - 1)) - 1;
    lo   = -(longint'(1) << (w - 1));
    d = '0;
    f = '0;
    for (int k = 0; k < 256 / w; k++) begin
      x = longint'(a >> (k * w)) & mask;
      y = longint'(b >> (k * w)) & mask;
      if (x > hi) x = x - (mask + 1);
      if (y > hi) y = y - (mask + 1);
      r = op ? x - y : x + y;
      if (sat && r > hi) begin r = hi; f[k] = 1'b1; end
      if (sat && r < lo) begin r = lo; f[k] = 1'b1; end
      d = d | (256'(r & mask) << (k * w));
    end
  endfunction

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic [255:0] a, input logic [255:0] b,
                      input logic op, input logic [1:0] mode, input logic sat);
    logic [255:0] d;
    logic [31:0]  f;
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_op = op; in_mode = mode; in_sat = sat;
    while (!in_ready) @(negedge clk);
    ref_model(a, b, op, mode, sat, d, f);
    exp_d.push_back(d);
    exp_f.push_back(f);
    exp_t.push_back(tag);
  endtask

  // scoreboard monitor, samples at the falling edge
  initial begin
    logic [255:0] held_d;
    logic [31:0]  held_f;
    bit stalled = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (stalled && out_valid) begin
          check("R11 data hold", out_data, held_d);
          check("R11 flag hold", 256'(out_flags), 256'(held_f));
        end
        stalled = 1'b0;
        if (out_valid && !out_ready) begin
          stalled = 1'b1;
          held_d = out_data;
          held_f = out_flags;
          check("R11 in_ready low", 256'(in_ready), 256'(0));
        end
        if (out_valid && out_ready) begin
          if (exp_d.size() == 0) begin
            check("R10 unexpected output", 256'(1), 256'(0));
          end else begin
            string t;
            t = exp_t.pop_front();
            check({t, " data"}, out_data, exp_d.pop_front());
            check({"R7 flags ", t}, 256'(out_flags), 256'(exp_f.pop_front()));
          end
        end
      end
    end
  end

  // output back-pressure, changed away from both edges
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = bp_en ? ($urandom_range(0, 2) != 0) : 1'b1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [255:0] ra, rb;
    repeat (3) @(negedge clk);
    check("R12 out_valid reset", 256'(out_valid), 256'(0));
    check("R12 in_ready reset", 256'(in_ready), 256'(1));
    rst_n = 1'b1;
    send("R8 R1 byte wrap", {32{8'hFF}}, {32{8'h01}}, 1'b0, 2'b00, 1'b0);
    send("R6 byte sat high", {32{8'h7F}}, {32{8'h01}}, 1'b0, 2'b00, 1'b1);
    send("R5 R6 byte sat low", {32{8'h80}}, {32{8'h01}}, 1'b1, 2'b00, 1'b1);
    send("R5 R6 neg of min", {32{8'h00}}, {32{8'h80}}, 1'b1, 2'b00, 1'b1);
    send("R9 R2 half wrap", {16{16'h7FFF}}, {16{16'h0001}}, 1'b0, 2'b01, 1'b0);
    send("R3 word inner carry", {8{32'h0000FFFF}}, {8{32'h00000001}}, 1'b0, 2'b10, 1'b0);
    send("R8 word borrow", {8{32'h00000000}}, {8{32'h00000001}}, 1'b1, 2'b10, 1'b0);
    send("R4 complex real sat", {8{32'h0001_7FFF}}, {8{32'h0001_0001}}, 1'b0, 2'b11, 1'b1);
    send("R4 complex imag sat", {8{32'h8000_0005}}, {8{32'h0001_0003}}, 1'b1, 2'b11, 1'b1);
    bp_en = 1'b1;
    for (int m = 0; m < 4; m++)
      for (int o = 0; o < 2; o++)
        for (int s = 0; s < 2; s++)
          for (int n = 0; n < 20; n++) begin
            for (int j = 0; j < 8; j++) begin
              ra[32*j +: 32] = $urandom;
              rb[32*j +: 32] = $urandom;
            end
            send(m == 0 ? "R1 R9 random" : m == 1 ? "R2 R6 random" :
                 m == 2 ? "R3 R5 random" : "R4 R8 random",
                 ra, rb, o[0], m[1:0], s[0]);
          end
    @(negedge clk);
    in_valid = 1'b0;
    bp_en = 1'b0;
    while (exp_d.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule